// File: doc/BRIEF.md
# Message-Matched Frame Resynchronisation Pulse Generator

This block sits on the base-station side of a digital subscriber line. It watches the words received on the embedded operations channel and compares each valid word with a programmed match value. A match does not act at once. It arms a pending request, and the request is released as a single resynchronisation pulse at the next rising edge of the receive frame-sync input. Downstream logic uses that pulse to preset the base station's radio frame counter. When the same word is repeated back to back, only one pulse is produced. A new match is accepted only after a non-matching word has been seen.

The block also generates the local frame-alignment strobe. It normally free-runs from a period counter that counts timebase ticks. When the lock enable is set and the line is active, the strobe is instead placed a fixed number of ticks after each receive frame-sync rising edge, and the period counter is realigned to it. With the default settings this offset is five 12.5 µs ticks, which is 62.5 µs.

Top module: `frame_resync_gen`

## Requirements
- R1: A cycle with `eoc_valid` high and `eoc_word` equal to `match_word` sets a pending request if the matcher is armed, and that request later yields exactly one rising edge on `resync_o`.
- R2: `resync_o` rises in the cycle after the first rising edge of `rx_fs` that is sampled while a request is already pending. A match that arrives in the same cycle as an `rx_fs` rising edge waits for the next rising edge.
- R3: Once high, `resync_o` stays high until the clock edge that samples the first `tick` of its high period, and it is low in the following cycle.
- R4: After a match, further matching words do not create new requests. The matcher re-arms only on a valid word that differs from `match_word`.
- R5: Word values presented while `eoc_valid` is low have no effect on the armed or pending state or on `resync_o`.
- R6: While `lock_en` or `line_active` is low, `fa_strobe_o` is a one-cycle pulse in the cycle after every FRAME_TICKS-th `tick` counted by the period counter.
- R7: While `lock_en` and `line_active` are both high, the free-running strobe is suppressed. `fa_strobe_o` pulses in the cycle after the OFFSET_TICKS-th `tick` that follows an `rx_fs` rising edge (ticks in the edge cycle are not counted), and the period counter restarts from zero at that point.
- R8: During and right after reset, `resync_o` and `fa_strobe_o` are low, the matcher is armed, no request is pending, and the period counter is at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe (one per symbol period) |
| eoc_word | input | EOC_W | Received operations-channel word |
| eoc_valid | input | 1 | Qualifies `eoc_word` for one cycle |
| match_word | input | EOC_W | Programmed value that triggers a resync |
| rx_fs | input | 1 | Receive frame-sync; its rising edges are used |
| line_active | input | 1 | Line is activated |
| lock_en | input | 1 | Enables locking of the frame-alignment strobe |
| resync_o | output | 1 | Resynchronisation pulse, one tick long |
| fa_strobe_o | output | 1 | Local frame-alignment strobe, one cycle |

## Verification
Some properties are checked on every cycle: the pulse drops after a tick, the pulse starts only from a frame-sync edge that finds a request pending, a request appears only while the matcher is armed, the armed state holds when no word is valid, and every strobe follows a tick. Other behaviour needs a run of stimulus to show. This includes the deferral of a match that coincides with an edge, the single pulse for repeated copies of the message, re-arming after a different word, the lock being ignored until the line is active, and the placement of the locked strobe relative to frame sync. The bench covers these with a cycle-by-cycle reference model and with pulse counts taken per scenario.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [1:0] {
        FA_FREERUN    = 2'd0,
        FA_LOCK_IDLE  = 2'd1,
        FA_LOCK_COUNT = 2'd2
    } fa_mode_e;

    typedef struct packed {
        logic armed;
        logic pending;
    } match_state_t;

    typedef struct packed {
        logic fs_prev;
        logic pulse;
    } pulse_state_t;

endpackage

// File: rtl/frs_eoc_matcher.sv
module frs_eoc_matcher
    import frs_pkg::*;
#(
    parameter int EOC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EOC_W-1:0] word_i,
    input  logic             valid_i,
    input  logic [EOC_W-1:0] ref_i,
    input  logic             consume_i,
    output logic             pending_o,
    output logic             armed_o
);

    match_state_t st_d, st_q;
    logic hit;
    logic set_req;

    always_comb begin
        hit     = valid_i && (word_i == ref_i);
        set_req = hit && st_q.armed;
        st_d    = st_q;
        if (valid_i) begin
            st_d.armed = !hit;
        end
        if (set_req) begin
            st_d.pending = 1'b1;
        end else if (consume_i) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b1, pending: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o = st_q.pending;
    assign armed_o   = st_q.armed;

endmodule

// File: rtl/frs_resync_pulse.sv
module frs_resync_pulse
    import frs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic fs_i,
    input  logic pending_i,
    output logic fs_edge_o,
    output logic consume_o,
    output logic pulse_o
);

    pulse_state_t st_d, st_q;
    logic fire;

    always_comb begin
        fs_edge_o  = fs_i && !st_q.fs_prev;
        fire       = fs_edge_o && pending_i && !st_q.pulse;
        st_d       = st_q;
        st_d.fs_prev = fs_i;
        if (st_q.pulse) begin
            st_d.pulse = !tick_i;
        end else begin
            st_d.pulse = fire;
        end
        consume_o = fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fs_prev: 1'b0, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/frs_fa_gen.sv
module frs_fa_gen
    import frs_pkg::*;
#(
    parameter int FRAME_TICKS  = 120,
    parameter int OFFSET_TICKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic fs_edge_i,
    input  logic locked_i,
    output logic strobe_o
);

    localparam int CW = (FRAME_TICKS > 1) ? $clog2(FRAME_TICKS) : 1;
    localparam int OW = $clog2(OFFSET_TICKS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FRAME_TICKS - 1);
    localparam logic [OW-1:0] OFF_LOAD = OW'(OFFSET_TICKS);
    localparam logic [OW-1:0] OFF_ONE  = OW'(1);

    typedef struct packed {
        fa_mode_e        mode;
        logic [CW-1:0]   cnt;
        logic [OW-1:0]   off;
        logic            strobe;
    } fa_state_t;

    fa_state_t st_d, st_q;
    logic wrap;

    always_comb begin
        wrap        = tick_i && (st_q.cnt == CNT_LAST);
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (tick_i) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        end
        if (!locked_i) begin
            st_d.mode   = FA_FREERUN;
            st_d.off    = '0;
            st_d.strobe = wrap;
        end else if (fs_edge_i) begin
            st_d.mode = FA_LOCK_COUNT;
            st_d.off  = OFF_LOAD;
        end else if (st_q.mode == FA_LOCK_COUNT) begin
            if (tick_i) begin
                if (st_q.off == OFF_ONE) begin
                    st_d.strobe = 1'b1;
                    st_d.cnt    = '0;
                    st_d.mode   = FA_LOCK_IDLE;
                    st_d.off    = '0;
                end else begin
                    st_d.off = st_q.off - 1'b1;
                end
            end
        end else begin
            st_d.mode = FA_LOCK_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: FA_FREERUN, cnt: '0, off: '0, strobe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = st_q.strobe;

endmodule

// File: rtl/frame_resync_gen.sv
module frame_resync_gen #(
    parameter int EOC_W        = 12,
    parameter int FRAME_TICKS  = 120,
    parameter int OFFSET_TICKS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [EOC_W-1:0] eoc_word,
    input  logic             eoc_valid,
    input  logic [EOC_W-1:0] match_word,
    input  logic             rx_fs,
    input  logic             line_active,
    input  logic             lock_en,
    output logic             resync_o,
    output logic             fa_strobe_o
);

    logic pend;
    logic armed;
    logic consume;
    logic fs_edge;
    logic locked;

    assign locked = lock_en && line_active;

    frs_eoc_matcher #(.EOC_W(EOC_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_i    (eoc_word),
        .valid_i   (eoc_valid),
        .ref_i     (match_word),
        .consume_i (consume),
        .pending_o (pend),
        .armed_o   (armed)
    );

    frs_resync_pulse u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .fs_i      (rx_fs),
        .pending_i (pend),
        .fs_edge_o (fs_edge),
        .consume_o (consume),
        .pulse_o   (resync_o)
    );

    frs_fa_gen #(
        .FRAME_TICKS  (FRAME_TICKS),
        .OFFSET_TICKS (OFFSET_TICKS)
    ) u_fa (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .fs_edge_i (fs_edge),
        .locked_i  (locked),
        .strobe_o  (fa_strobe_o)
    );

endmodule

// File: rtl/frame_resync_chk.sv
module frame_resync_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic eoc_valid,
    input logic resync_o,
    input logic fa_strobe_o,
    input logic fs_edge,
    input logic pend,
    input logic armed
);

    // R3: the pulse ends after the first tick it sees
    a_r3_pulse_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_o && tick) |=> !resync_o);

    // R2: a pulse starts only from a frame-sync edge that found a request waiting
    a_r2_pulse_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resync_o) |-> $past(fs_edge && pend));

    // R4: a request can appear only while the matcher is armed
    a_r4_request_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(armed));

    // R5: without a valid word the armed state is untouched
    a_r5_invalid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_valid |=> $stable(armed));

    // R6: every frame-alignment strobe follows a tick
    a_r6_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        fa_strobe_o |-> $past(tick));

endmodule

bind frame_resync_gen frame_resync_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .eoc_valid   (eoc_valid),
    .resync_o    (resync_o),
    .fa_strobe_o (fa_strobe_o),
    .fs_edge     (fs_edge),
    .pend        (pend),
    .armed       (armed)
);

// File: tb/frame_resync_gen_tb_top.sv
module frame_resync_gen_tb_top;

    localparam int W   = 12;
    localparam int FT  = 8;
    localparam int OFF = 5;
    localparam logic [W-1:0] MATCH = 12'hA5C;
    localparam logic [W-1:0] OTHER = 12'h3C1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [W-1:0] eoc_word = '0;
    logic eoc_valid = 1'b0;
    logic [W-1:0] match_word = MATCH;
    logic rx_fs = 1'b0;
    logic line_active = 1'b0;
    logic lock_en = 1'b0;
    logic resync_o;
    logic fa_strobe_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    frame_resync_gen #(.EOC_W(W), .FRAME_TICKS(FT), .OFFSET_TICKS(OFF)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .eoc_word(eoc_word),
        .eoc_valid(eoc_valid), .match_word(match_word), .rx_fs(rx_fs),
        .line_active(line_active), .lock_en(lock_en),
        .resync_o(resync_o), .fa_strobe_o(fa_strobe_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // timebase: one tick every third cycle
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick <= (tdiv == 0);
    end

    // behavioural reference model
    bit m_armed = 1, m_pend = 0, m_fsp = 0, m_res = 0, m_fa = 0, m_run = 0, m_lockp = 0;
    int m_cnt = 0, m_off = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_armed = 1; m_pend = 0; m_fsp = 0; m_res = 0; m_fa = 0;
            m_run = 0; m_cnt = 0; m_off = 0; m_lockp = 0;
        end else begin
            bit edge_now, lk, nres, nfa, took;
            edge_now = rx_fs && !m_fsp;
            lk = lock_en && line_active;
            took = 0;
            if (m_res) nres = !tick;
            else begin nres = edge_now && m_pend; took = nres; end
            if (took) m_pend = 0;
            if (eoc_valid) begin
                if (eoc_word == match_word) begin
                    if (m_armed) m_pend = 1;
                    m_armed = 0;
                end else m_armed = 1;
            end
            nfa = 0;
            if (!lk) begin
                m_run = 0;
                if (tick && m_cnt == FT - 1) nfa = 1;
                if (tick) m_cnt = (m_cnt + 1) % FT;
            end else begin
                if (tick) m_cnt = (m_cnt + 1) % FT;
                if (edge_now) begin m_run = 1; m_off = OFF; end
                else if (m_run && tick) begin
                    m_off--;
                    if (m_off == 0) begin nfa = 1; m_run = 0; m_cnt = 0; end
                end
            end
            m_res = nres; m_fa = nfa; m_fsp = rx_fs; m_lockp = lk;
        end
    end

    // every-cycle comparison and event counters
    int n_res = 0, n_fa = 0;
    bit prev_res = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            check("R8 resync in reset", resync_o, 0);
            check("R8 strobe in reset", fa_strobe_o, 0);
        end else begin
            check("R2,R3 resync vs model", resync_o, m_res);
            check(m_lockp ? "R7 strobe vs model" : "R6 strobe vs model", fa_strobe_o, m_fa);
        end
        if (resync_o && !prev_res) n_res++;
        if (fa_strobe_o) n_fa++;
        prev_res = resync_o;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [W-1:0] w, input bit v);
        @(negedge clk);
        eoc_word = w; eoc_valid = v;
        @(negedge clk);
        eoc_valid = 1'b0;
    endtask

    task automatic fs_pulse();
        @(negedge clk);
        rx_fs = 1'b1;
        idle(2);
        rx_fs = 1'b0;
        idle(8);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 resync after reset", resync_o, 0);
        check("R8 strobe after reset", fa_strobe_o, 0);

        // R6 free-running strobe
        idle(80);
        check("R6 free-run strobes seen", int'(n_fa > 0), 1);

        // R1/R2: match waits for frame-sync edge
        send(MATCH, 1'b1);
        idle(12);
        check("R2 no pulse before edge", n_res, 0);
        fs_pulse();
        check("R1 one pulse after match", n_res, 1);

        // R4: repeats without a differing word give nothing
        send(MATCH, 1'b1); send(MATCH, 1'b1); send(MATCH, 1'b1);
        fs_pulse();
        check("R4 repeat without rearm", n_res, 1);
        send(OTHER, 1'b1);
        send(MATCH, 1'b1); send(MATCH, 1'b1); send(MATCH, 1'b1);
        fs_pulse(); fs_pulse();
        check("R4 three copies one pulse", n_res, 2);

        // R5: invalid words are ignored
        send(OTHER, 1'b1);
        send(MATCH, 1'b0); send(MATCH, 1'b0);
        fs_pulse();
        check("R5 invalid match ignored", n_res, 2);
        send(MATCH, 1'b1);
        fs_pulse();
        check("R5 armed state kept", n_res, 3);

        // R2: match coincident with edge is deferred
        send(OTHER, 1'b1);
        @(negedge clk);
        eoc_word = MATCH; eoc_valid = 1'b1; rx_fs = 1'b1;
        @(negedge clk);
        eoc_valid = 1'b0;
        idle(1);
        rx_fs = 1'b0;
        idle(8);
        check("R2 coincident match deferred", n_res, 3);
        fs_pulse();
        check("R2 pulse on next edge", n_res, 4);

        // R7: lock needs an active line
        lock_en = 1'b1;
        n_fa = 0;
        idle(60);
        check("R7 inactive line free-runs", int'(n_fa > 0), 1);
        line_active = 1'b1;
        idle(4);
        n_fa = 0;
        @(negedge clk); rx_fs = 1'b1;
        idle(2); rx_fs = 1'b0;
        idle(40);
        check("R7 single offset strobe", n_fa, 1);
        n_fa = 0;
        idle(60);
        check("R7 free-run suppressed", n_fa, 0);
        fs_pulse();
        idle(20);
        check("R7 strobe per edge", n_fa, 1);

        // back to free-run
        lock_en = 1'b0;
        n_fa = 0;
        idle(60);
        check("R6 free-run resumes", int'(n_fa > 0), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule